// File: doc/BRIEF.md
# Trigger Accept Dead-Time Throttle

This block sits on the level-1 accept path, running on the bunch-crossing clock. It passes a raw trigger request through as an accept only when three conditions allow it. The first is a short fixed dead time that follows every accept. The second is a leaky-bucket credit limit that stops the front-end derandomisers from filling faster than they drain. The third is a BUSY line raised by full downstream buffers.

Any request that one of these conditions blocks is flagged as vetoed. It is also counted, once for each condition that was present. The dead-time length, bucket capacity and leak period come in as static configuration inputs. Typical settings are a 4-crossing dead time, a capacity of 8 and a leak every 400 crossings, which amounts to 8 accepts per 3200 crossings (80 µs at 40 MHz).

The accept and veto outputs are combinational in the request, so the throttle adds no crossing of latency to the trigger.

Top module: `trig_throttle`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises with no request, accept_o and veto_o are 0 and all three veto counters read 0.
- R2: A request (req_i high) with no veto cause present gives accept_o = 1 in the same cycle.
- R3: After an accept in cycle t, requests in cycles t+1 .. t+dead_len_i are vetoed for dead time; dead_len_i = 0 imposes no dead time.
- R4: The bucket level starts at 0 after reset and rises by one for each accept. While the level is greater than or equal to bucket_cap_i, requests are vetoed for the bucket.
- R5: A leak timer starts at 0 after reset and counts crossings. In every cycle where it equals leak_period_i - 1, it wraps to 0 and the level drops by one if it is nonzero. An accept and a leak in the same cycle cancel. leak_period_i must be at least 1.
- R6: A request while busy_i is high is vetoed.
- R7: A vetoed request changes neither the bucket level nor the dead-time window.
- R8: Three counters, for dead time, bucket and busy, each rise by one on every vetoed request in which their cause is present. Several can rise together, and each saturates at its all-ones value.
- R9: veto_o = req_i and (any cause present); accept_o and veto_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Raw level-1 accept request |
| busy_i | input | 1 | Downstream buffers full |
| dead_len_i | input | DEAD_W | Dead-time crossings after each accept |
| bucket_cap_i | input | LVL_W | Bucket capacity |
| leak_period_i | input | LEAK_W | Crossings between bucket leaks (>= 1) |
| accept_o | output | 1 | Gated accept |
| veto_o | output | 1 | Request vetoed this cycle |
| cnt_dead_o | output | CNT_W | Vetoes with dead time present |
| cnt_bucket_o | output | CNT_W | Vetoes with bucket full |
| cnt_busy_o | output | CNT_W | Vetoes with BUSY present |

## Verification
A wrong dead-time count or bucket level shows up at accept_o in the very next request cycle. It appears as a lost accept or as an extra accept that breaks the credit limit. A leak timer that has drifted out of phase only shows up after a full leak period, and only once the bucket has filled. For that reason the sweeps use short periods and dense requests. Counter faults show up at once, since every counter is compared on every cycle, both through saturation and when causes overlap.

// File: rtl/trig_throttle_pkg.sv
package trig_throttle_pkg;
  localparam int unsigned CAUSE_DEAD   = 0;
  localparam int unsigned CAUSE_BUCKET = 1;
  localparam int unsigned CAUSE_BUSY   = 2;
  localparam int unsigned NUM_CAUSES   = 3;
endpackage

// File: rtl/tt_dead_timer.sv
module tt_dead_timer #(
  parameter int unsigned DEAD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [DEAD_W-1:0] len_i,
  output logic              dead_o
);
  logic [DEAD_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             remain_q <= '0;
    else if (acc_i)          remain_q <= len_i;
    else if (remain_q != 0)  remain_q <= remain_q - 1'b1;
  end

  assign dead_o = (remain_q != 0);

  p_dead_after_acc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (dead_o == ($past(len_i) != 0)));
  p_hold_no_acc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !dead_o) |=> !dead_o);
endmodule

// File: rtl/tt_bucket.sv
module tt_bucket #(
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned LEAK_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [LVL_W-1:0]  cap_i,
  input  logic [LEAK_W-1:0] period_i,
  output logic              full_o
);
  logic [LVL_W-1:0]  level_q;
  logic [LEAK_W-1:0] tmr_q;
  logic              tick;
  logic              leak;

  assign tick = (tmr_q == period_i - 1'b1);
  assign leak = tick && (level_q != 0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tmr_q <= '0;
    else if (tick) tmr_q <= '0;
    else           tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            level_q <= '0;
    else if (acc_i && !leak) level_q <= level_q + 1'b1;
    else if (!acc_i && leak) level_q <= level_q - 1'b1;
  end

  assign full_o = (level_q >= cap_i);

  p_period_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_i != 0);
  p_no_acc_when_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> !full_o);
  p_stable_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !tick) |=> $stable(level_q));
endmodule

// File: rtl/tt_sat_counter.sv
module tt_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (inc_i && ~&cnt_o)   cnt_o <= cnt_o + 1'b1;
  end

  p_saturate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o) |=> (&cnt_o));
  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/trig_throttle.sv
module trig_throttle
  import trig_throttle_pkg::*;
#(
  parameter int unsigned DEAD_W = 4,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned LEAK_W = 12,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              busy_i,
  input  logic [DEAD_W-1:0] dead_len_i,
  input  logic [LVL_W-1:0]  bucket_cap_i,
  input  logic [LEAK_W-1:0] leak_period_i,
  output logic              accept_o,
  output logic              veto_o,
  output logic [CNT_W-1:0]  cnt_dead_o,
  output logic [CNT_W-1:0]  cnt_bucket_o,
  output logic [CNT_W-1:0]  cnt_busy_o
);
  logic                  dead, full;
  logic [NUM_CAUSES-1:0] cause;
  logic [CNT_W-1:0]      cnt [NUM_CAUSES];

  tt_dead_timer #(.DEAD_W(DEAD_W)) u_dead (
    .clk_i, .rst_ni, .acc_i(accept_o), .len_i(dead_len_i), .dead_o(dead)
  );

  tt_bucket #(.LVL_W(LVL_W), .LEAK_W(LEAK_W)) u_bucket (
    .clk_i, .rst_ni, .acc_i(accept_o), .cap_i(bucket_cap_i),
    .period_i(leak_period_i), .full_o(full)
  );

  always_comb begin
    cause               = '0;
    cause[CAUSE_DEAD]   = dead;
    cause[CAUSE_BUCKET] = full;
    cause[CAUSE_BUSY]   = busy_i;
  end

  assign veto_o   = req_i && (cause != '0);
  assign accept_o = req_i && !veto_o;

  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cnt
    tt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .inc_i(veto_o && cause[g]), .cnt_o(cnt[g])
    );
  end

  assign cnt_dead_o   = cnt[CAUSE_DEAD];
  assign cnt_bucket_o = cnt[CAUSE_BUCKET];
  assign cnt_busy_o   = cnt[CAUSE_BUSY];

  p_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && veto_o));
  p_busy_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !accept_o);
  p_dead_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && dead_len_i != 0) |=> !accept_o);
  p_veto_counts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (veto_o && busy_i && !(&cnt_busy_o)) |=> (cnt_busy_o == $past(cnt_busy_o) + 1'b1));
endmodule

// File: tb/tb_trig_throttle.sv
module tb_trig_throttle;
  localparam int unsigned DW = 4, LW = 4, KW = 12, CW = 4;
  localparam int unsigned CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, req = 1'b0, busy = 1'b0;
  logic [DW-1:0] dlen = '0;
  logic [LW-1:0] cap = '0;
  logic [KW-1:0] per = 12'd1;
  logic acc, veto;
  logic [CW-1:0] c_dead, c_bkt, c_busy;

  int tests = 0, fails = 0;
  int m_dead, m_lvl, m_tmr, m_cd, m_cb, m_cy;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  trig_throttle #(.DEAD_W(DW), .LVL_W(LW), .LEAK_W(KW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .busy_i(busy),
    .dead_len_i(dlen), .bucket_cap_i(cap), .leak_period_i(per),
    .accept_o(acc), .veto_o(veto), .cnt_dead_o(c_dead),
    .cnt_bucket_o(c_bkt), .cnt_busy_o(c_busy)
  );

  task automatic chk(input string req_tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (dead=%0d cap=%0d per=%0d)",
               req_tag, act, exp, dlen, cap, per);
    end
  endtask

  task automatic run_cfg(input int d, input int c, input int p, input int density, input int ncyc);
    @(negedge clk);
    rst_ni = 1'b0; req = 1'b0; busy = 1'b0;
    dlen = DW'(d); cap = LW'(c); per = KW'(p);
    @(negedge clk);
    #1;
    chk("R1 reset accept", int'(acc), 0);
    chk("R1 reset counters", int'(c_dead) + int'(c_bkt) + int'(c_busy), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_dead = 0; m_lvl = 0; m_tmr = 0; m_cd = 0; m_cb = 0; m_cy = 0;
    for (int i = 0; i < ncyc; i++) begin
      bit tick, dd, ff, ea, ev;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req  = (int'(lfsr[3:0]) < density);
      busy = (lfsr[9:7] == 3'b111);
      #1;
      tick = (m_tmr == p - 1);
      dd   = (m_dead != 0);
      ff   = (m_lvl >= c);
      ea   = req && !dd && !ff && !busy;
      ev   = req && !ea;
      if (i == 0) chk("R1 first cycle counters", int'(c_dead) + int'(c_bkt) + int'(c_busy), 0);
      if (ea) chk("R2 accept", int'(acc), 1);
      else if (dd && req) chk("R3 dead veto", int'(acc), 0);
      else if (ff && req) chk("R4 bucket veto", int'(acc), 0);
      else if (busy && req) chk("R6 busy veto", int'(acc), 0);
      else chk("R9 idle accept", int'(acc), 0);
      chk("R9 veto flag", int'(veto), int'(ev));
      chk("R8 dead counter", int'(c_dead), m_cd);
      chk("R8 bucket counter (R5 R7 leak/level)", int'(c_bkt), m_cb);
      chk("R8 busy counter", int'(c_busy), m_cy);
      // state after the coming edge
      if (ev && dd && m_cd < CMAX) m_cd++;
      if (ev && ff && m_cb < CMAX) m_cb++;
      if (ev && busy && m_cy < CMAX) m_cy++;
      if (ea) m_dead = d; else if (dd) m_dead--;
      m_lvl = m_lvl + int'(ea) - int'(tick && m_lvl != 0);
      m_tmr = tick ? 0 : m_tmr + 1;
      @(negedge clk);
    end
    req = 1'b0; busy = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int dl[3] = '{0, 1, 4};
    int cp[4] = '{0, 1, 3, 8};
    int pr[3] = '{1, 5, 40};
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 3; k++)
          run_cfg(dl[a], cp[b], pr[k], (a + b + k) % 2 ? 12 : 6, 250);
    // bucket drains, then single accepts at leak rate (R5)
    run_cfg(0, 2, 3, 16, 120);
    // dead time only, long window (R3)
    run_cfg(15, 15, 1, 16, 200);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule